// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block captures a word of parallel data and sends it out one bit at a time. It is used where a wide set of signals has to pass through a single wire, for example when a controller polls a bank of switches or status lines. An active-low capture strobe copies the whole word into the register. After the strobe is released, each qualified clock event moves the contents one place toward the last stage, and a serial input fills the first stage. The last stage is presented on a true output and on a complemented output, so several units can be chained with either polarity.

The whole block runs on one system clock. The external shift clock and the inhibit pin are sampled as ordinary data inputs. Their logical OR forms an effective clock, which is registered every cycle, and a shift happens on the system edge at which that registered value goes from 0 to 1. Because the OR is symmetric, either pin can serve as the clock while the other is held low, and holding either pin high freezes the register. A capture overrides shifting in every case. The clock history keeps tracking during a capture, so a clock that rose while the strobe was low does not produce a shift when the strobe is released.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage and the effective-clock history. After reset, ser_out is 0 and ser_out_n is 1.
- R2: When load_n is 0 at a system edge, stage i takes par_in[i] at that edge, whatever sclk, sinh and ser_in are doing. Bit 0 is the first stage and bit WIDTH-1 is the last stage.
- R3: When load_n is 1 at a system edge and sclk|sinh is 1 at that edge but was 0 at the previous edge, the register shifts once toward the last stage. At that edge, stage i takes stage i-1 and the first stage takes ser_in.
- R4: With sclk held at 0, a rising sinh causes exactly the same single shift that a rising sclk does.
- R5: While load_n is 1 and either sclk or sinh stays at 1, the contents are frozen. Toggling the other pin, or a falling transition of the OR, causes no shift.
- R6: ser_out always shows the last stage. A bit entered at ser_in reaches ser_out after WIDTH shifts.
- R7: ser_out_n is always the complement of ser_out.
- R8: A rise of sclk|sinh that happens while load_n is 0 causes no shift after load_n returns to 1, as long as the OR stays at 1.
- R9: Loading the pattern (first stage to last) 1,0,1,0,1,0,1,1 gives ser_out = 1 on the next cycle. Seven shifts after that give 1,0,1,0,1,0,1 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel capture strobe |
| par_in | input | WIDTH | Parallel word; bit 0 feeds the first stage |
| ser_in | input | 1 | Serial data entering the first stage on a shift |
| sclk | input | 1 | Shift clock pin, sampled by the system clock |
| sinh | input | 1 | Clock-inhibit pin, interchangeable with sclk |
| ser_out | output | 1 | Last stage, true polarity |
| ser_out_n | output | 1 | Last stage, complemented |

## Verification
The bench builds the block with its default WIDTH of 8. This width is small enough that a full serial drain of every loaded word takes only eight shifts, so a few thousand cycles of mixed load, clock and inhibit activity reach each ordering of capture, shift, freeze and release many times over. Directed sequences cover the following cases:
- the stated example pattern;
- the inhibit pin acting as the clock;
- freezing with either pin held high;
- a clock that rises while the strobe is low.

An arithmetic model in the bench predicts both outputs every cycle.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Registered view of the effective shift clock (sclk | sinh).
    typedef struct packed {
        logic eff;
    } clk_hist_t;

    localparam clk_hist_t CLK_HIST_RESET = '{eff: 1'b0};

endpackage

// File: rtl/piso_edge.sv
module piso_edge
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sinh,
    output logic rise
);

    clk_hist_t hist_d, hist_q;
    logic      eff_now;

    always_comb begin
        eff_now    = sclk | sinh;
        rise       = eff_now & ~hist_q.eff;
        hist_d     = hist_q;
        hist_d.eff = eff_now;
        if (rst) begin
            hist_d = CLK_HIST_RESET;
        end
    end

    always_ff @(posedge clk) begin
        hist_q <= hist_d;
    end

    // R3: a rise is a single-cycle event; the history must follow it
    p_single_rise_r3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] bits
);

    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } stage_st_t;

    stage_st_t        st_d, st_q;
    logic [WIDTH-1:0] shifted;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign shifted[i] = ser_in;
        end else begin : g_next
            assign shifted[i] = st_q.bits[i-1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.bits = par_in;
        end else if (shift_en) begin
            st_d.bits = shifted;
        end
        if (rst) begin
            st_d.bits = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bits = st_q.bits;

    // R1: reset empties every stage
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (st_q.bits == '0));

    // R2: capture takes the parallel word
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (st_q.bits == $past(par_in)));

    // R3: one place toward the last stage, serial bit at the first
    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (load_n && shift_en) |=>
            (st_q.bits == {$past(st_q.bits[LAST-1:0]), $past(ser_in)}));

    // R5: no rise and no capture means the contents hold
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (load_n && !shift_en) |=> $stable(st_q.bits));

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             sclk,
    input  logic             sinh,
    output logic             ser_out,
    output logic             ser_out_n
);

    localparam int LAST = WIDTH - 1;

    logic             rise;
    logic [WIDTH-1:0] bits;

    piso_edge i_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .sinh (sinh),
        .rise (rise)
    );

    piso_stages #(.WIDTH(WIDTH)) i_stages (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .shift_en (rise),
        .par_in   (par_in),
        .ser_in   (ser_in),
        .bits     (bits)
    );

    assign ser_out   = bits[LAST];
    assign ser_out_n = ~bits[LAST];

    // R5: with sclk held high, the output cannot move outside a capture
    p_freeze_out_r5: assert property (@(posedge clk) disable iff (rst)
        (load_n && sclk && $past(sclk)) |=> $stable(ser_out));

endmodule

// File: tb/test_piso_shift_reg.sv
module test_piso_shift_reg;

    localparam int W      = 8;
    localparam int PERIOD = 10;
    localparam int LIMIT  = 200000;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_n;
    logic [W-1:0] par_in;
    logic         ser_in;
    logic         sclk;
    logic         sinh;
    logic         ser_out;
    logic         ser_out_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [W-1:0] m_reg = '0;
    logic         m_eff = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    piso_shift_reg #(.WIDTH(W)) i_piso_shift_reg (
        .clk       (clk),
        .rst       (rst),
        .load_n    (load_n),
        .par_in    (par_in),
        .ser_in    (ser_in),
        .sclk      (sclk),
        .sinh      (sinh),
        .ser_out   (ser_out),
        .ser_out_n (ser_out_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // Apply one cycle of inputs, advance the model at the edge, sample at negedge.
    task automatic step(input logic r, input logic ld, input logic [W-1:0] p,
                        input logic s, input logic ck, input logic ih);
        logic eff_now;
        rst = r; load_n = ld; par_in = p; ser_in = s; sclk = ck; sinh = ih;
        @(posedge clk);
        eff_now = ck | ih;
        if (r) begin
            m_reg = '0;
            m_eff = 1'b0;
        end else begin
            if (!ld)                 m_reg = p;
            else if (eff_now && !m_eff) m_reg = {m_reg[W-2:0], s};
            m_eff = eff_now;
        end
        @(negedge clk);
        cycles++;
    endtask

    task automatic both(input string tag);
        chk(tag, ser_out, m_reg[W-1]);
        chk("R7", ser_out_n, ~m_reg[W-1]);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1, 1, '0, 0, 0, 0);
        step(1, 1, '0, 0, 0, 0);
        chk("R1", ser_out, 1'b0);
        chk("R1", ser_out_n, 1'b1);
        step(0, 1, '0, 0, 0, 0);

        // R2: capture while sclk toggles and ser_in is high
        step(0, 0, 8'hD5, 1, 1, 0);
        chk("R2", ser_out, 1'b1);
        step(0, 0, 8'h55, 1, 0, 1);
        chk("R2", ser_out, 1'b0);
        step(0, 0, 8'h80, 0, 1, 1);
        chk("R2", ser_out, 1'b1);
        step(0, 1, 8'h00, 0, 0, 0);

        // R9: example pattern, sclk as clock
        step(0, 0, 8'hD5, 0, 0, 0);
        chk("R9", ser_out, 1'b1);
        step(0, 1, 8'h00, 0, 0, 0);
        for (int k = 0; k < 7; k++) begin
            step(0, 1, 8'h00, 0, 1, 0);
            chk("R9", ser_out, (k % 2 == 0) ? 1'b1 : 1'b0);
            step(0, 1, 8'h00, 0, 0, 0);
            both("R3");
        end

        // R4 and R6: sinh as clock, a 1 travels from ser_in to ser_out in W shifts
        step(0, 0, 8'h00, 0, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0);
        for (int k = 0; k < W; k++) begin
            step(0, 1, 8'h00, (k == 0), 0, 1);
            chk("R4", ser_out, (k == W-1));
            step(0, 1, 8'h00, 0, 0, 0);
        end
        chk("R6", ser_out, 1'b1);

        // R5: sclk held high, sinh toggled, no movement; falling OR no shift
        step(0, 0, 8'h80, 0, 1, 0);
        step(0, 1, 8'h00, 0, 1, 0);
        for (int k = 0; k < 6; k++) begin
            step(0, 1, 8'h00, 1, 1, k[0]);
            chk("R5", ser_out, 1'b1);
        end
        step(0, 1, 8'h00, 1, 0, 0);
        chk("R5", ser_out, 1'b1);
        step(0, 1, 8'h00, 0, 0, 1);
        chk("R4", ser_out, 1'b0);
        // sinh held high now freezes while sclk toggles
        for (int k = 0; k < 4; k++) begin
            step(0, 1, 8'h00, 1, k[0], 1);
            chk("R5", ser_out, 1'b0);
        end
        step(0, 1, 8'h00, 0, 0, 0);

        // R8: rise during capture, release with clock still high
        step(0, 0, 8'h80, 0, 0, 0);
        step(0, 0, 8'h80, 0, 1, 0);
        for (int k = 0; k < 3; k++) begin
            step(0, 1, 8'h00, 0, 1, 0);
            chk("R8", ser_out, 1'b1);
        end
        step(0, 1, 8'h00, 0, 0, 0);
        chk("R8", ser_out, 1'b1);

        // Mid-run reset, then R1 again
        step(1, 1, 8'h00, 0, 0, 0);
        chk("R1", ser_out, 1'b0);
        chk("R1", ser_out_n, 1'b1);
        step(0, 1, 8'h00, 0, 0, 0);

        // Mixed sweep against the model
        for (int k = 0; k < 4000; k++) begin
            logic ld = ($urandom_range(0, 7) != 0);
            step(0, ld, W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
            both("R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule